// File: doc/BRIEF.md
# Field Burst-Boundary Zero Padder

This stream stage sits between a producer of compressed 32-bit words and a downstream FIFO that is emptied in fixed-size bursts. It counts the words of each field. When the producer marks the final word of a field, the stage appends all-zero words until the total length of the field is a whole multiple of the selected burst length. Every field therefore leaves the stage ending exactly on a burst boundary, and a burst-based reader never has to deal with a short final burst.

Both sides use a valid/ready handshake and carry an end-of-field marker. The output side is a single register stage. The burst length is a power of two picked by a small select input. That select is sampled once, on the first word of each field. While zero words are being inserted, the input side stays blocked, so the next field cannot begin until the current one is complete.

Top module: `field_burst_padder`

## Requirements
- R1: Every accepted input word appears on the output once, with its 32-bit value unchanged, in arrival order.
- R2: The burst length is 2^(MIN_LOG2 + burst_sel). With the default MIN_LOG2 = 5, the codes 0, 1, 2 and 3 select 32, 64, 128 and 256 words.
- R3: When a field's word count N is not a multiple of the burst length L, exactly (L - N mod L) words of value zero follow the field's last data word.
- R4: When a field's word count is already a multiple of L, no zero words are inserted, and out_last is set on the last data word.
- R5: out_last is set on exactly one output word per field: the final padding word, or the last data word when no padding is needed. The number of output words up to and including it is a multiple of L.
- R6: From the cycle the last data word of a field that needs padding is accepted until the final padding word has been loaded, in_ready is low.
- R7: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values into the next cycle.
- R8: burst_sel is sampled on the cycle the first word of a field is accepted. Changes to it later in the same field have no effect on that field's padding.
- R9: After reset, out_valid is low, in_ready is high, and the word count of the first field starts at zero.
- R10: The word count restarts at zero for every field, so each field is padded according to its own length only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_sel | input | SEL_W | Burst length select, sampled at field start |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept an input word |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Input word is the last of its field |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output word (data or zero padding) |
| out_last | output | 1 | Output word ends the padded field |

## Verification
The bench goes after fields of one word, which need the longest run of zeros (L-1). A counter that is off by one here would emit one padding word too many or too few. It also sends fields of exactly one and several bursts. A design that pads these anyway would add a full burst of zeros. Fields start back to back with a new field waiting at the input, so a design that did not block its input during padding would mix data words into the zeros. A change of burst_sel in the middle of a field shows whether the length is wrongly taken from the live input. Random backpressure shows whether output words are dropped or changed while the output is stalled.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [0:0] {
        ST_PASS = 1'b0,
        ST_PAD  = 1'b1
    } fbp_state_e;

endpackage

// File: rtl/fbp_len_decode.sv
module fbp_len_decode #(
    parameter int SEL_W    = 2,
    parameter int MIN_LOG2 = 5,
    parameter int CNT_W    = MIN_LOG2 + (1 << SEL_W) - 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] mask
);
    localparam int NUM_LEN = 1 << SEL_W;

    logic [CNT_W-1:0] mask_tab [NUM_LEN];

    for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
        localparam logic [CNT_W:0] LEN = (CNT_W+1)'(1) << (MIN_LOG2 + g);
        localparam logic [CNT_W:0] MSK = LEN - (CNT_W+1)'(1);
        assign mask_tab[g] = MSK[CNT_W-1:0];
    end

    assign mask = mask_tab[sel];

endmodule

// File: rtl/fbp_beat_counter.sv
module fbp_beat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [CNT_W-1:0] mask,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_next
);
    logic [CNT_W-1:0] cnt_d, cnt_q, inc;

    always_comb begin
        inc   = (cnt_q + CNT_W'(1)) & mask;
        cnt_d = cnt_q;
        if (step) begin
            cnt_d = clear ? '0 : inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt       = cnt_q;
    assign wrap_next = (inc == '0);

    // the position inside a burst never exceeds the current length
    assert_cnt_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q & ~mask) == '0);

endmodule

// File: rtl/field_burst_padder.sv
module field_burst_padder
    import fbp_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 2,
    parameter int MIN_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  burst_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam int CNT_W = MIN_LOG2 + (1 << SEL_W) - 1;

    typedef struct packed {
        fbp_state_e        state;
        logic              first;
        logic [SEL_W-1:0]  sel;
        logic              o_valid;
        logic [DATA_W-1:0] o_data;
        logic              o_last;
        logic              o_pad;
    } regs_t;

    regs_t d, q;

    logic             slot_free, accept, pad_emit, load, fld_end, wrap_next;
    logic [SEL_W-1:0] eff_sel;
    logic [CNT_W-1:0] mask, cnt;

    assign slot_free = !q.o_valid || out_ready;
    assign eff_sel   = q.first ? burst_sel : q.sel;
    assign in_ready  = (q.state == ST_PASS) && slot_free;
    assign accept    = in_valid && in_ready;
    assign pad_emit  = (q.state == ST_PAD) && slot_free;
    assign load      = accept || pad_emit;

    fbp_len_decode #(
        .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2), .CNT_W(CNT_W)
    ) u_len (
        .sel (eff_sel),
        .mask(mask)
    );

    fbp_beat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (load),
        .clear    (fld_end),
        .mask     (mask),
        .cnt      (cnt),
        .wrap_next(wrap_next)
    );

    always_comb begin
        d       = q;
        fld_end = 1'b0;
        if (q.o_valid && out_ready) begin
            d.o_valid = 1'b0;
        end
        if (accept) begin
            d.o_valid = 1'b1;
            d.o_data  = in_data;
            d.o_pad   = 1'b0;
            d.o_last  = 1'b0;
            if (q.first) begin
                d.sel   = burst_sel;
                d.first = 1'b0;
            end
            if (in_last) begin
                if (wrap_next) begin
                    d.o_last = 1'b1;
                    d.first  = 1'b1;
                    fld_end  = 1'b1;
                end else begin
                    d.state = ST_PAD;
                end
            end
        end else if (pad_emit) begin
            d.o_valid = 1'b1;
            d.o_data  = '0;
            d.o_pad   = 1'b1;
            d.o_last  = 1'b0;
            if (wrap_next) begin
                d.o_last = 1'b1;
                d.first  = 1'b1;
                d.state  = ST_PASS;
                fld_end  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_PASS;
            q.first   <= 1'b1;
            q.sel     <= '0;
            q.o_valid <= 1'b0;
            q.o_data  <= '0;
            q.o_last  <= 1'b0;
            q.o_pad   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.o_valid;
    assign out_data  = q.o_data;
    assign out_last  = q.o_last;

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] xfer_q;
    logic [CNT_W-1:0] xfer_mask;

    fbp_len_decode #(
        .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2), .CNT_W(CNT_W)
    ) u_len_chk (
        .sel (q.sel),
        .mask(xfer_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= '0;
        end else if (out_valid && out_ready) begin
            xfer_q <= out_last ? '0 : xfer_q + CNT_W'(1);
        end
    end

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && q.o_pad) |-> (out_data == '0));

    assert_last_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |->
            (((xfer_q + CNT_W'(1)) & xfer_mask) == '0));

    assert_no_input_while_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PAD) |-> !in_ready);

    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

// File: tb/tb_field_burst_padder.sv
module tb_field_burst_padder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  burst_sel = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    always #5 clk = ~clk;

    field_burst_padder dut (
        .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    typedef struct {
        logic [31:0] d;
        logic        l;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   bp_on = 1'b0;
    bit   done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: set ready at negedge, then look at the handshake before the next edge
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected output word", {32'h0, out_data}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data == e.d, e.tag, "data", {32'h0, out_data}, {32'h0, e.d});
                check(out_last == e.l, "R5", "last flag", {63'h0, out_last}, {63'h0, e.l});
            end
        end
    end

    // driver: sends one field and queues the expected output
    task automatic send_field(int n, int sel0, int chg_at, int sel1, logic [31:0] seed, string tag);
        int len;
        int pad;
        len = 1 << (5 + sel0);
        pad = (len - (n % len)) % len;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.d = seed + 32'(i);
            e.l = (i == n - 1) && (pad == 0);
            e.tag = (pad == 0 && i == n - 1) ? "R4" : tag;
            exp_q.push_back(e);
        end
        for (int i = 0; i < pad; i++) begin
            exp_t e;
            e.d = 32'h0;
            e.l = (i == pad - 1);
            e.tag = "R3";
            exp_q.push_back(e);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            burst_sel = (i == 0) ? 2'(sel0) : ((chg_at >= 0 && i >= chg_at) ? 2'(sel1) : 2'(sel0));
            in_valid = 1'b1;
            in_data  = seed + 32'(i);
            in_last  = (i == n - 1);
            #2;
            while (!in_ready) begin
                @(negedge clk);
                #2;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9", "out_valid after reset", {63'h0, out_valid}, 64'h0);
        check(in_ready == 1'b1, "R9", "in_ready after reset", {63'h0, in_ready}, 64'h1);
        rst_n = 1'b1;

        send_field(5,   0, -1, 0, 32'h8000_0100, "R1");   // R3: 27 zeros
        send_field(32,  0, -1, 0, 32'h8100_0000, "R1");   // R4: aligned
        send_field(33,  0, -1, 0, 32'h8200_0000, "R10");  // R10: 31 zeros
        send_field(130, 2, -1, 0, 32'h8300_0000, "R2");   // R2: 126 zeros
        send_field(1,   3, -1, 0, 32'h8400_0000, "R3");   // R3: 255 zeros
        bp_on = 1'b1;
        send_field(64,  1, -1, 0, 32'h8500_0000, "R7");   // R7: stalled, aligned
        send_field(10,  0, 3,  3, 32'h8600_0000, "R8");   // R8: 22 zeros despite sel change
        send_field(3,   1, -1, 0, 32'h8700_0000, "R6");   // R6: next field waits
        send_field(7,   0, -1, 0, 32'h8800_0000, "R6");
        bp_on = 1'b0;
        send_field(256, 3, -1, 0, 32'h8900_0000, "R4");   // R4: one full large burst
        send_field(65,  1, 1,  0, 32'h8A00_0000, "R8");   // R8: 63 zeros at length 64

        for (int t = 0; t < 2000 && exp_q.size() != 0; t++) @(posedge clk);
        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R3", "missing output words", 64'(exp_q.size()), 64'h0);
        check(out_valid == 1'b0, "R5", "idle after last field", {63'h0, out_valid}, 64'h0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule